// File: doc/BRIEF.md
# Systolic Matrix-Multiply Grid with Handshaked Channels

This block computes C = A x B for an A matrix of ROWS x KDIM and a B matrix of KDIM x COLS. All elements are 32-bit unsigned integers. It is built as a grid of (ROWS+1) x (COLS+1) positions, and each position takes a role from its coordinate. The positions in grid row zero are loaders that bring the columns of B into the array. The positions in grid column zero, below the corner, are loaders that bring the rows of A. Each remaining position is a compute cell. A compute cell multiplies the A operand arriving from its left by the B operand arriving from above, adds the product into its accumulator, and forwards both operands onward. The A operand goes right and the B operand goes down. Each hop between positions passes through a small FIFO with valid/ready flow control.

A run starts with a start pulse while the block is idle. The block then accepts KDIM beats on each operand stream. When every compute cell has finished its KDIM steps, a collection phase returns the accumulators one at a time on a handshaked result stream, followed by a one-cycle done pulse. The grid size and KDIM are fixed when the block is elaborated. The design is meant for grids from 2x2 to 4x4.

Top module: `sysmm_grid`

## Requirements
- R1: The position at grid row 0 and column c (c >= 1) feeds B column c-1 downward. The position at grid row r (r >= 1) and column 0 feeds A row r-1 to the right. Every other position (r, c) with r, c >= 1 accumulates the element C[r-1][c-1].
- R2: Each result equals the sum over k of A[i][k]*B[k][j], computed modulo 2^32.
- R3: A start pulse accepted in the idle phase sets every accumulator to zero. No value from an earlier run carries into the new one.
- R4: After a start, exactly KDIM beats are accepted on each operand stream. Beat k of the A stream carries A[i][k] in a_data bits [i*32 +: 32]. Beat k of the B stream carries B[k][j] in b_data bits [j*32 +: 32]. The signals a_ready and b_ready are low in every other phase.
- R5: An operand beat transfers only in a cycle where valid and ready are both high. Inputs that are held while ready is low, or that arrive with gaps between beats, still give correct results.
- R6: Results appear only after every compute cell has completed KDIM steps. They are then returned in row-major order, one element per res_valid/res_ready handshake, ROWS*COLS elements in total.
- R7: While res_valid is high and res_ready is low, res_valid stays high and res_data holds its value.
- R8: done is high for exactly one cycle, the cycle after the handshake of the last result element. res_valid is low in that cycle.
- R9: A start pulse during the operand or collection phase is ignored. The run in progress completes with unchanged results.
- R10: After reset, a_ready, b_ready, res_valid and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| a_valid | input | 1 | A beat valid |
| a_ready | output | 1 | A beat accepted when high together with a_valid |
| a_data | input | ROWS*32 | One A element per row for the current inner step |
| b_valid | input | 1 | B beat valid |
| b_ready | output | 1 | B beat accepted when high together with b_valid |
| b_data | input | COLS*32 | One B element per column for the current inner step |
| res_valid | output | 1 | Result element valid |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | 32 | Result element, row-major order |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The assertions run on every cycle and check the handshake rules at the block's edge. These are the operand beat budget per run, the closed inputs while idle, the wait for both full operand sets before any result, the holding of a stalled result, and the single done pulse after the full count of results. Other behaviours show up only in the bench's scenarios. The correctness of the product, its row-major order, the modulo-2^32 wrap and the clearing between runs are checked there. So is the effect of a start pulse while a run is in progress. The scenarios use identity, zero, all-ones and random matrices, with random gaps on the operand streams and random backpressure on the result stream.

// File: rtl/sysmm_pkg.sv
// Shared types for the systolic grid.
// Assumes grid coordinates count from the top-left corner, with row 0 and column 0 as the loader edges.
package sysmm_pkg;

    typedef enum logic [1:0] {
        ROLE_CORNER = 2'd0,
        ROLE_B_FEED = 2'd1,
        ROLE_A_FEED = 2'd2,
        ROLE_MAC    = 2'd3
    } cell_role_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    // Role of a grid position, decided by its coordinate alone.
    function automatic cell_role_e cell_role(input int r, input int c);
        if (r == 0 && c == 0) return ROLE_CORNER;
        if (r == 0)           return ROLE_B_FEED;
        if (c == 0)           return ROLE_A_FEED;
        return ROLE_MAC;
    endfunction

endpackage

// File: rtl/sysmm_fifo.sv
// Small synchronous FIFO used as the channel between neighbouring grid positions.
// Assumes the writer pushes only while full is low. A pop while empty has no effect.
module sysmm_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          full,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign valid   = (fill != '0);
    assign dout    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write, with no reset needed on the data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/sysmm_pe.sv
// Compute cell. It consumes one A and one B operand per step, accumulates their product modulo 2^DW,
// and forwards the operands to its right and lower neighbours.
// Assumes the downstream full flags are tied low on the grid edge where no neighbour exists.
module sysmm_pe #(
    parameter int DW   = 32,
    parameter int KDIM = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [DW-1:0] a_in,
    input  logic          a_vld,
    input  logic [DW-1:0] b_in,
    input  logic          b_vld,
    input  logic          right_full,
    input  logic          down_full,
    output logic          fire,
    output logic [DW-1:0] acc,
    output logic          finished
);
    localparam int SW = $clog2(KDIM + 1);

    logic [SW-1:0] steps;

    assign finished = (steps == SW'(KDIM));
    assign fire     = a_vld && b_vld && !right_full && !down_full && !finished;

    // Multiply-accumulate and step counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            steps <= '0;
        end else if (clear) begin
            acc   <= '0;
            steps <= '0;
        end else if (fire) begin
            acc   <= acc + a_in * b_in;
            steps <= steps + SW'(1);
        end
    end
endmodule

// File: rtl/sysmm_sequencer.sv
// Phase control. It opens the operand streams for KDIM beats each, waits for all cells to finish,
// then returns the accumulators in row-major order and pulses done.
// Assumes acc_flat packs cell (i,j) at index i*COLS+j.
module sysmm_sequencer
    import sysmm_pkg::*;
#(
    parameter int DW   = 32,
    parameter int KDIM = 2,
    parameter int NCELL = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                a_fire,
    input  logic                b_fire,
    input  logic                all_finished,
    input  logic                res_ready,
    input  logic [NCELL*DW-1:0] acc_flat,
    output logic                clear,
    output logic                a_open,
    output logic                b_open,
    output logic                res_valid,
    output logic [DW-1:0]       res_data,
    output logic                done
);
    localparam int KW = $clog2(KDIM + 1);
    localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1;

    phase_e        phase;
    logic [KW-1:0] a_cnt, b_cnt;
    logic [IW-1:0] idx;

    assign clear     = start && (phase == PH_IDLE);
    assign a_open    = (phase == PH_LOAD) && (a_cnt != KW'(KDIM));
    assign b_open    = (phase == PH_LOAD) && (b_cnt != KW'(KDIM));
    assign res_valid = (phase == PH_DRAIN);
    assign res_data  = acc_flat[DW*int'(idx) +: DW];

    // Phase transitions, beat counters and result index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            a_cnt <= '0;
            b_cnt <= '0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        a_cnt <= '0;
                        b_cnt <= '0;
                    end
                end
                PH_LOAD: begin
                    if (a_fire) a_cnt <= a_cnt + KW'(1);
                    if (b_fire) b_cnt <= b_cnt + KW'(1);
                    if (all_finished) begin
                        phase <= PH_DRAIN;
                        idx   <= '0;
                    end
                end
                PH_DRAIN: begin
                    if (res_ready) begin
                        if (idx == IW'(NCELL - 1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sysmm_grid.sv
// Top of the systolic multiply grid. Positions on row 0 feed B, positions on column 0 feed A,
// and the interior positions are compute cells. Each operand hop is a FIFO channel.
// Assumes KDIM >= 1 and a grid of ROWS x COLS compute cells with ROWS, COLS >= 1.
module sysmm_grid
    import sysmm_pkg::*;
#(
    parameter int ROWS       = 2,
    parameter int COLS       = 2,
    parameter int KDIM       = 2,
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 a_valid,
    output logic                 a_ready,
    input  logic [ROWS*DW-1:0]   a_data,
    input  logic                 b_valid,
    output logic                 b_ready,
    input  logic [COLS*DW-1:0]   b_data,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [DW-1:0]        res_data,
    output logic                 done
);
    localparam int NCELL = ROWS * COLS;

    logic [DW-1:0] aq_din  [ROWS][COLS];
    logic [DW-1:0] aq_dout [ROWS][COLS];
    logic          aq_push [ROWS][COLS];
    logic          aq_full [ROWS][COLS];
    logic          aq_vld  [ROWS][COLS];
    logic [DW-1:0] bq_din  [ROWS][COLS];
    logic [DW-1:0] bq_dout [ROWS][COLS];
    logic          bq_push [ROWS][COLS];
    logic          bq_full [ROWS][COLS];
    logic          bq_vld  [ROWS][COLS];
    logic          pe_fire [ROWS][COLS];

    logic [NCELL-1:0]    pe_fin;
    logic [NCELL*DW-1:0] acc_flat;
    logic [ROWS-1:0]     a_room;
    logic [COLS-1:0]     b_room;
    logic                clear, a_open, b_open, a_fire, b_fire;

    assign a_ready = a_open && (&a_room);
    assign b_ready = b_open && (&b_room);
    assign a_fire  = a_valid && a_ready;
    assign b_fire  = b_valid && b_ready;

    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
        for (genvar gj = 0; gj < COLS; gj++) begin : g_col
            logic right_full, down_full;

            // A channel into compute cell (gi,gj): from the A loader on the left edge, or from the left neighbour.
            if (cell_role(gi + 1, gj) == ROLE_A_FEED) begin : g_a_src
                assign aq_push[gi][gj] = a_fire;
                assign aq_din[gi][gj]  = a_data[gi*DW +: DW];
                assign a_room[gi]      = !aq_full[gi][gj];
            end else begin : g_a_fwd
                assign aq_push[gi][gj] = pe_fire[gi][gj-1];
                assign aq_din[gi][gj]  = aq_dout[gi][gj-1];
            end

            // B channel into compute cell (gi,gj): from the B loader on the top edge, or from the upper neighbour.
            if (cell_role(gi, gj + 1) == ROLE_B_FEED) begin : g_b_src
                assign bq_push[gi][gj] = b_fire;
                assign bq_din[gi][gj]  = b_data[gj*DW +: DW];
                assign b_room[gj]      = !bq_full[gi][gj];
            end else begin : g_b_fwd
                assign bq_push[gi][gj] = pe_fire[gi-1][gj];
                assign bq_din[gi][gj]  = bq_dout[gi-1][gj];
            end

            // Backpressure from the downstream channels, absent on the far edges.
            if (gj == COLS - 1) begin : g_re
                assign right_full = 1'b0;
            end else begin : g_rn
                assign right_full = aq_full[gi][gj+1];
            end
            if (gi == ROWS - 1) begin : g_de
                assign down_full = 1'b0;
            end else begin : g_dn
                assign down_full = bq_full[gi+1][gj];
            end

            sysmm_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_aq (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (aq_push[gi][gj]),
                .din   (aq_din[gi][gj]),
                .full  (aq_full[gi][gj]),
                .pop   (pe_fire[gi][gj]),
                .dout  (aq_dout[gi][gj]),
                .valid (aq_vld[gi][gj])
            );

            sysmm_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_bq (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (bq_push[gi][gj]),
                .din   (bq_din[gi][gj]),
                .full  (bq_full[gi][gj]),
                .pop   (pe_fire[gi][gj]),
                .dout  (bq_dout[gi][gj]),
                .valid (bq_vld[gi][gj])
            );

            sysmm_pe #(.DW(DW), .KDIM(KDIM)) u_pe (
                .clk        (clk),
                .rst_n      (rst_n),
                .clear      (clear),
                .a_in       (aq_dout[gi][gj]),
                .a_vld      (aq_vld[gi][gj]),
                .b_in       (bq_dout[gi][gj]),
                .b_vld      (bq_vld[gi][gj]),
                .right_full (right_full),
                .down_full  (down_full),
                .fire       (pe_fire[gi][gj]),
                .acc        (acc_flat[(gi*COLS+gj)*DW +: DW]),
                .finished   (pe_fin[gi*COLS+gj])
            );
        end
    end

    sysmm_sequencer #(.DW(DW), .KDIM(KDIM), .NCELL(NCELL)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .a_fire       (a_fire),
        .b_fire       (b_fire),
        .all_finished (&pe_fin),
        .res_ready    (res_ready),
        .acc_flat     (acc_flat),
        .clear        (clear),
        .a_open       (a_open),
        .b_open       (b_open),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .done         (done)
    );
endmodule

// File: rtl/sysmm_grid_checker.sv
// Port-level protocol checks for sysmm_grid, attached by bind.
// Assumes it sees the same clock and reset as the grid.
module sysmm_grid_checker #(
    parameter int ROWS = 2,
    parameter int COLS = 2,
    parameter int KDIM = 2,
    parameter int DW   = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          a_valid,
    input logic          a_ready,
    input logic          b_valid,
    input logic          b_ready,
    input logic          res_valid,
    input logic          res_ready,
    input logic [DW-1:0] res_data,
    input logic          done
);
    localparam int NCELL = ROWS * COLS;

    logic busy;
    int   a_seen, b_seen, r_seen;

    // Independent run tracking from port activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            a_seen <= 0;
            b_seen <= 0;
            r_seen <= 0;
        end else begin
            if (!busy && start) begin
                busy   <= 1'b1;
                a_seen <= 0;
                b_seen <= 0;
                r_seen <= 0;
            end else begin
                if (a_valid && a_ready) a_seen <= a_seen + 1;
                if (b_valid && b_ready) b_seen <= b_seen + 1;
                if (res_valid && res_ready) begin
                    r_seen <= r_seen + 1;
                    if (r_seen == NCELL - 1) busy <= 1'b0;
                end
            end
        end
    end

    p_a_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |-> (a_seen < KDIM));
    p_b_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |-> (b_seen < KDIM));
    p_closed_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!a_ready && !b_ready && !res_valid));
    p_res_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (a_seen == KDIM && b_seen == KDIM));
    p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_seen == NCELL && !res_valid));
endmodule

bind sysmm_grid sysmm_grid_checker #(
    .ROWS (ROWS),
    .COLS (COLS),
    .KDIM (KDIM),
    .DW   (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .a_valid   (a_valid),
    .a_ready   (a_ready),
    .b_valid   (b_valid),
    .b_ready   (b_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .done      (done)
);

// File: tb/sysmm_grid_tb.sv
// Self-checking bench for sysmm_grid on a 3x3 grid with an inner dimension of 4.
module sysmm_grid_tb;
    localparam int ROWS = 3;
    localparam int COLS = 3;
    localparam int KDIM = 4;
    localparam int DW   = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                a_valid = 1'b0;
    logic                a_ready;
    logic [ROWS*DW-1:0]  a_data = '0;
    logic                b_valid = 1'b0;
    logic                b_ready;
    logic [COLS*DW-1:0]  b_data = '0;
    logic                res_valid;
    logic                res_ready = 1'b0;
    logic [DW-1:0]       res_data;
    logic                done;

    int unsigned mat_a [ROWS][KDIM];
    int unsigned mat_b [KDIM][COLS];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cycles  = 0;
    bit          finished = 1'b0;
    bit          poke_start = 1'b0;
    int unsigned bp_pct = 0;

    always #10 clk = ~clk;

    sysmm_grid #(.ROWS(ROWS), .COLS(COLS), .KDIM(KDIM), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .done(done)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int unsigned ref_elem(input int i, input int j);
        int unsigned s = 0;
        for (int k = 0; k < KDIM; k++) s += mat_a[i][k] * mat_b[k][j];
        return s;
    endfunction

    task automatic drive_a();
        for (int k = 0; k < KDIM; k++) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                a_valid = 1'b0;
            end
            @(negedge clk);
            a_valid = 1'b1;
            for (int i = 0; i < ROWS; i++) a_data[i*DW +: DW] = mat_a[i][k];
            #1;
            while (!a_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        a_valid = 1'b0;
    endtask

    task automatic drive_b();
        for (int k = 0; k < KDIM; k++) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                b_valid = 1'b0;
            end
            @(negedge clk);
            b_valid = 1'b1;
            for (int j = 0; j < COLS; j++) b_data[j*DW +: DW] = mat_b[k][j];
            #1;
            while (!b_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        b_valid = 1'b0;
    endtask

    task automatic collect(input string tag);
        logic        stalled = 1'b0;
        logic [31:0] held = '0;
        for (int n = 0; n < ROWS*COLS; n++) begin
            bit got = 1'b0;
            while (!got) begin
                @(negedge clk);
                res_ready = (($urandom % 100) >= bp_pct);
                #1;
                if (stalled && res_valid)
                    check({tag, " R7 held data"}, res_data, held);
                stalled = res_valid && !res_ready;
                held    = res_data;
                if (res_valid && res_ready) begin
                    // R1 R2 R6: row-major position n = i*COLS+j
                    check({tag, " R2 R6 element"}, res_data, ref_elem(n / COLS, n % COLS));
                    got = 1'b1;
                end
            end
            if (poke_start && n == 0) begin
                @(negedge clk);
                res_ready = 1'b0;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                stalled = 1'b0;
            end
        end
        @(negedge clk);
        res_ready = 1'b0;
        #1;
        check({tag, " R8 done pulse"}, {31'd0, done}, 32'd1);
        check({tag, " R8 no valid with done"}, {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        #1;
        check({tag, " R8 done one cycle"}, {31'd0, done}, 32'd0);
        check({tag, " R4 ready closed after run"}, {30'd0, a_ready, b_ready}, 32'd0);
    endtask

    task automatic run_case(input string tag);
        @(negedge clk);
        #1;
        check({tag, " R4 closed before start"}, {30'd0, a_ready, b_ready}, 32'd0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            drive_a();
            drive_b();
            collect(tag);
        join
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        #1;
        check("R10 a_ready reset", {31'd0, a_ready}, 32'd0);
        check("R10 b_ready reset", {31'd0, b_ready}, 32'd0);
        check("R10 res_valid reset", {31'd0, res_valid}, 32'd0);
        check("R10 done reset", {31'd0, done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R10 idle after reset", {29'd0, a_ready, b_ready, res_valid}, 32'd0);

        // Identity A times random B: result rows copy B rows (R1).
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < KDIM; k++) mat_a[i][k] = (i == k) ? 1 : 0;
        for (int k = 0; k < KDIM; k++)
            for (int j = 0; j < COLS; j++) mat_b[k][j] = $urandom;
        bp_pct = 0;
        run_case("identity R1");

        // All-ones-bit values: each product wraps to 1 (R2).
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < KDIM; k++) mat_a[i][k] = 32'hFFFF_FFFF;
        for (int k = 0; k < KDIM; k++)
            for (int j = 0; j < COLS; j++) mat_b[k][j] = 32'hFFFF_FFFF;
        bp_pct = 40;
        run_case("wrap R2");

        // Zero matrix after a nonzero run: accumulators must have been cleared (R3).
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < KDIM; k++) mat_a[i][k] = 0;
        bp_pct = 30;
        run_case("zero R3");

        // Random matrices with backpressure (R5, R7).
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < ROWS; i++)
                for (int k = 0; k < KDIM; k++) mat_a[i][k] = $urandom;
            for (int k = 0; k < KDIM; k++)
                for (int j = 0; j < COLS; j++) mat_b[k][j] = (t == 0) ? ($urandom % 256) : $urandom;
            bp_pct = 20 + 15 * t;
            run_case("random R5");
        end

        // Start pulse during result collection must be ignored (R9).
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < KDIM; k++) mat_a[i][k] = $urandom % 1000;
        for (int k = 0; k < KDIM; k++)
            for (int j = 0; j < COLS; j++) mat_b[k][j] = $urandom % 1000;
        poke_start = 1'b1;
        bp_pct = 25;
        run_case("busy start R9");
        poke_start = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule